// File: doc/BRIEF.md
# Shiftable Multi-Level Pixel Window Store

This block holds an 8x8 window of image pixels for an array of 64 processing lanes. Every cell drives exactly one lane. On command, the window moves by one pixel position in one of four directions. Only the edge that the move exposes is refilled, using eight new pixels taken from a single input bus. A convolution engine can therefore step across an image while it reads just eight pixels for every 64 cell updates.

The store keeps four separate window levels, so four images can be resident at the same time. Two read ports each pick any level and present all 64 cells of that level together. Each level carries its own pixel format flag:

- In narrow mode the cell is read as an 8-bit unsigned value and zero-extended to 16 bits.
- In wide mode the stored 16-bit signed value is passed through unchanged.

A row-load operation writes one complete row in a single cycle. Eight such operations fill a level before stepping begins.

Top module: `pixwin_cache`

## Requirements
- R1: After reset, every cell of every level reads as zero on both read ports.
- R2: A shift with direction code 00 (left) on level L makes cell (r,c) take the old value of (r,c+1) for c<7. A shift with code 01 (right) makes (r,c) take the old value of (r,c-1) for c>0. The update takes one clock.
- R3: A shift with direction code 10 (up) makes cell (r,c) take the old value of (r+1,c) for r<7. A shift with code 11 (down) makes (r,c) take the old value of (r-1,c) for r>0.
- R4: In the same cycle as the shift, the vacated edge is filled from the eight lanes of the pixel bus. Lane i is bits [16i+15:16i]. A left shift writes lane i into (i,7). A right shift writes lane i into (i,0). An up shift writes lane i into (7,i). A down shift writes lane i into (0,i).
- R5: Each level has a format bit, bit L of `lvl_wide`. When the bit is 0, a port reading that level outputs {8'h00, stored[7:0]} for every cell. When the bit is 1, the port outputs the stored 16-bit value unchanged.
- R6: A shift or row load on one level leaves the other three levels unchanged.
- R7: A row load writes lane i of the pixel bus into cell (row_sel, i) of the selected level, one row per clock.
- R8: When a shift and a row load are requested in the same cycle, only the shift is performed.
- R9: The two read ports select their levels independently, and both present their levels at the same time. Cell (r,c) appears at bits [16(8r+c)+15 : 16(8r+c)].
- R10: With no shift and no row load requested, the stored contents of every level hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_shift | input | 1 | Shift the selected level by one pixel and refill its edge |
| op_row | input | 1 | Write one full row of the selected level |
| op_dir | input | 2 | Shift direction: 00 left, 01 right, 10 up, 11 down |
| op_lvl | input | 2 | Level targeted by a shift or row load |
| op_row_sel | input | 3 | Row index for a row load |
| op_pix | input | 128 | Eight 16-bit pixel lanes for edge fill or row load |
| lvl_wide | input | 4 | Format bit per level: 1 wide signed, 0 narrow unsigned |
| rd_lvl_a | input | 2 | Level shown on port A |
| rd_lvl_b | input | 2 | Level shown on port B |
| win_a | output | 1024 | All 64 cells of the level selected for port A |
| win_b | output | 1024 | All 64 cells of the level selected for port B |

## Verification
Every cell of a level is loaded with a value that encodes its level, row and column, so a value that lands in the wrong position shows up as a mismatch on every cell it affects. Each of the four directions is applied while the second port watches a different level. This separates a wrong move or a wrong edge-lane mapping from a write that leaks into another level. Eight left shifts in a row replace a whole window with edge values only, which tests the edge path on its own. The stored pixels have non-zero high bytes, so reading them in narrow and in wide mode shows whether the extension is applied to the correct level. A cycle that requests both a shift and a row load confirms that the shift takes priority.

// File: rtl/pixwin_cache.sv
module pixwin_cache #(
  parameter int DIM    = 8,
  parameter int PW     = 16,
  parameter int LEVELS = 4,
  localparam int LW    = $clog2(LEVELS),
  localparam int RW    = $clog2(DIM),
  localparam int CELLS = DIM * DIM
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_shift,
  input  logic                  op_row,
  input  logic [1:0]            op_dir,
  input  logic [LW-1:0]         op_lvl,
  input  logic [RW-1:0]         op_row_sel,
  input  logic [DIM*PW-1:0]     op_pix,
  input  logic [LEVELS-1:0]     lvl_wide,
  input  logic [LW-1:0]         rd_lvl_a,
  input  logic [LW-1:0]         rd_lvl_b,
  output logic [CELLS*PW-1:0]   win_a,
  output logic [CELLS*PW-1:0]   win_b
);

  localparam logic [1:0] DIR_LEFT  = 2'b00;
  localparam logic [1:0] DIR_RIGHT = 2'b01;
  localparam logic [1:0] DIR_UP    = 2'b10;

  logic [PW-1:0] mem [LEVELS][DIM][DIM];
  logic [PW-1:0] cur [DIM][DIM];
  logic [PW-1:0] nxt [DIM][DIM];
  logic [LEVELS-1:0][CELLS*PW-1:0] raw;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam int CL = (c == DIM-1) ? c : c + 1;
      localparam int CR = (c == 0) ? c : c - 1;
      localparam int RU = (r == DIM-1) ? r : r + 1;
      localparam int RD = (r == 0) ? r : r - 1;
      logic [PW-1:0] from_l, from_r, from_u, from_d;

      assign cur[r][c] = mem[op_lvl][r][c];
      assign from_l = (c == DIM-1) ? op_pix[r*PW +: PW] : cur[r][CL];
      assign from_r = (c == 0)     ? op_pix[r*PW +: PW] : cur[r][CR];
      assign from_u = (r == DIM-1) ? op_pix[c*PW +: PW] : cur[RU][c];
      assign from_d = (r == 0)     ? op_pix[c*PW +: PW] : cur[RD][c];
      assign nxt[r][c] = (op_dir == DIR_LEFT)  ? from_l :
                         (op_dir == DIR_RIGHT) ? from_r :
                         (op_dir == DIR_UP)    ? from_u : from_d;

      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign raw[l][(r*DIM+c)*PW +: PW] = mem[l][r][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LEVELS; l++)
        for (int r = 0; r < DIM; r++)
          for (int c = 0; c < DIM; c++)
            mem[l][r][c] <= '0;
    end else if (op_shift) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          mem[op_lvl][r][c] <= nxt[r][c];
    end else if (op_row) begin
      for (int c = 0; c < DIM; c++)
        mem[op_lvl][op_row_sel][c] <= op_pix[c*PW +: PW];
    end
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_out
    logic [PW-1:0] va, vb;
    assign va = raw[rd_lvl_a][k*PW +: PW];
    assign vb = raw[rd_lvl_b][k*PW +: PW];
    assign win_a[k*PW +: PW] = lvl_wide[rd_lvl_a] ? va : {{(PW/2){1'b0}}, va[PW/2-1:0]};
    assign win_b[k*PW +: PW] = lvl_wide[rd_lvl_b] ? vb : {{(PW/2){1'b0}}, vb[PW/2-1:0]};
  end

endmodule

module pixwin_cache_chk #(
  parameter int DIM    = 8,
  parameter int PW     = 16,
  parameter int LEVELS = 4,
  localparam int LW    = $clog2(LEVELS),
  localparam int RW    = $clog2(DIM),
  localparam int CELLS = DIM * DIM
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            op_shift,
  input logic                            op_row,
  input logic [1:0]                      op_dir,
  input logic [LW-1:0]                   op_lvl,
  input logic [RW-1:0]                   op_row_sel,
  input logic [DIM*PW-1:0]               op_pix,
  input logic [LEVELS-1:0]               lvl_wide,
  input logic [LW-1:0]                   rd_lvl_a,
  input logic [CELLS*PW-1:0]             win_a,
  input logic [LEVELS-1:0][CELLS*PW-1:0] raw
);

  for (genvar g = 0; g < LEVELS; g++) begin : g_chk
    AST_SHIFT_LEFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_shift && op_dir == 2'b00 && op_lvl == LW'(g)) |=> raw[g][0 +: PW] == $past(raw[g][PW +: PW])); // R2
    AST_SHIFT_DOWN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_shift && op_dir == 2'b11 && op_lvl == LW'(g)) |=> raw[g][DIM*PW +: PW] == $past(raw[g][0 +: PW])); // R3
    AST_EDGE_FROM_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_shift && op_dir == 2'b00 && op_lvl == LW'(g)) |=> raw[g][(DIM-1)*PW +: PW] == $past(op_pix[0 +: PW])); // R4
    AST_OTHER_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_shift || op_row) && op_lvl != LW'(g)) |=> $stable(raw[g])); // R6
    AST_ROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_row && !op_shift && op_lvl == LW'(g) && op_row_sel == '0) |=> raw[g][0 +: DIM*PW] == $past(op_pix)); // R7
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_shift && !op_row) |=> $stable(raw)); // R10
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wide[rd_lvl_a] |-> (win_a[PW-1:PW/2] == '0 && win_a[CELLS*PW-1 -: PW/2] == '0)); // R5

endmodule

bind pixwin_cache pixwin_cache_chk #(.DIM(DIM), .PW(PW), .LEVELS(LEVELS)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_shift(op_shift), .op_row(op_row), .op_dir(op_dir),
  .op_lvl(op_lvl), .op_row_sel(op_row_sel), .op_pix(op_pix), .lvl_wide(lvl_wide),
  .rd_lvl_a(rd_lvl_a), .win_a(win_a), .raw(raw)
);

// File: tb/pixwin_cache_tb_top.sv
module pixwin_cache_tb_top;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_shift = 1'b0, op_row = 1'b0;
  logic [1:0] op_dir = '0, op_lvl = '0, rd_lvl_a = '0, rd_lvl_b = 2'd1;
  logic [2:0] op_row_sel = '0;
  logic [127:0] op_pix = '0;
  logic [3:0] lvl_wide = 4'hF;
  logic [1023:0] win_a, win_b;

  always #5 clk = ~clk;

  pixwin_cache dut_i (
    .clk(clk), .rst_n(rst_n), .op_shift(op_shift), .op_row(op_row), .op_dir(op_dir),
    .op_lvl(op_lvl), .op_row_sel(op_row_sel), .op_pix(op_pix), .lvl_wide(lvl_wide),
    .rd_lvl_a(rd_lvl_a), .rd_lvl_b(rd_lvl_b), .win_a(win_a), .win_b(win_b)
  );

  typedef struct {
    string         tag;
    logic [1023:0] exp_a;
    logic [1023:0] exp_b;
  } item_t;

  item_t q[$];
  logic [15:0] m [4][D][D];
  int checks = 0, errors = 0;

  function automatic logic [1023:0] view(input int l, input bit wide);
    logic [1023:0] v;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++)
        v[(r*D+c)*16 +: 16] = wide ? m[l][r][c] : {8'h00, m[l][r][c][7:0]};
    return v;
  endfunction

  function automatic logic [127:0] row_pix(input int l, input int r);
    logic [127:0] p;
    for (int c = 0; c < D; c++) p[c*16 +: 16] = 16'(16'h8100 + l*16'h1000 + r*16 + c);
    return p;
  endfunction

  function automatic logic [127:0] edge_pix(input int k);
    logic [127:0] p;
    for (int i = 0; i < D; i++) p[i*16 +: 16] = 16'(16'hC000 + k*16'h0100 + i);
    return p;
  endfunction

  task automatic op(input bit sh, input bit rw, input logic [1:0] dir, input logic [1:0] lvl,
                    input logic [2:0] rsel, input logic [127:0] px, input logic [1:0] la,
                    input logic [1:0] lb, input logic [3:0] fmt, input string tag);
    logic [15:0] t [D][D];
    @(negedge clk); #1;
    op_shift = sh; op_row = rw; op_dir = dir; op_lvl = lvl; op_row_sel = rsel; op_pix = px;
    rd_lvl_a = la; rd_lvl_b = lb; lvl_wide = fmt;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) t[r][c] = m[lvl][r][c];
    if (sh) begin
      for (int r = 0; r < D; r++)
        for (int c = 0; c < D; c++) begin
          case (dir)
            2'b00: if (c == D-1) t[r][c] = px[r*16 +: 16]; else t[r][c] = m[lvl][r][c+1];
            2'b01: if (c == 0)   t[r][c] = px[r*16 +: 16]; else t[r][c] = m[lvl][r][c-1];
            2'b10: if (r == D-1) t[r][c] = px[c*16 +: 16]; else t[r][c] = m[lvl][r+1][c];
            default: if (r == 0) t[r][c] = px[c*16 +: 16]; else t[r][c] = m[lvl][r-1][c];
          endcase
        end
    end else if (rw) begin
      for (int c = 0; c < D; c++) t[rsel][c] = px[c*16 +: 16];
    end
    @(posedge clk); #1;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) m[lvl][r][c] = t[r][c];
    op_shift = 1'b0; op_row = 1'b0;
    q.push_back('{tag, view(la, fmt[la]), view(lb, fmt[lb])});
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks += 2;
      if (win_a !== it.exp_a) begin
        errors++;
        $display("FAIL %s port A: actual %h expected %h", it.tag, win_a, it.exp_a);
      end
      if (win_b !== it.exp_b) begin
        errors++;
        $display("FAIL %s port B: actual %h expected %h", it.tag, win_b, it.exp_b);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < D; r++)
        for (int c = 0; c < D; c++) m[l][r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op(0, 0, 2'b00, 0, 0, '0, 0, 1, 4'hF, "R1 reset zero");
    op(0, 0, 2'b00, 0, 0, '0, 2, 3, 4'h0, "R1 reset zero narrow");
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < D; r++)
        op(0, 1, 2'b00, 2'(l), 3'(r), row_pix(l, r), 2'(l), 2'((l+1)%4), 4'hF, "R7 row load R6");
    op(1, 0, 2'b00, 0, 0, edge_pix(1), 0, 1, 4'hF, "R2 left R4 edge R6");
    op(1, 0, 2'b01, 0, 0, edge_pix(2), 0, 1, 4'hF, "R2 right R4 edge");
    op(1, 0, 2'b10, 0, 0, edge_pix(3), 0, 2, 4'hF, "R3 up R4 edge");
    op(1, 0, 2'b11, 0, 0, edge_pix(4), 0, 3, 4'hF, "R3 down R4 edge");
    op(1, 0, 2'b10, 1, 0, edge_pix(5), 0, 1, 4'hF, "R6 shift lvl1 others held");
    op(1, 1, 2'b01, 2, 3, row_pix(9, 9), 2, 3, 4'hF, "R8 shift wins over row");
    op(0, 0, 2'b00, 0, 0, '0, 0, 1, 4'b1110, "R5 narrow lvl0 wide lvl1");
    op(0, 0, 2'b00, 0, 0, '0, 2, 3, 4'b0111, "R5 wide lvl2 narrow lvl3");
    op(0, 0, 2'b00, 0, 0, '0, 3, 2, 4'hF, "R9 independent ports");
    op(0, 0, 2'b00, 0, 0, '0, 1, 1, 4'b1101, "R9 same level R5 narrow");
    for (int k = 0; k < D; k++)
      op(1, 0, 2'b00, 3, 0, edge_pix(16 + k), 3, 0, 4'hF, "R4 full left sweep");
    op(1, 0, 2'b11, 3, 0, edge_pix(30), 3, 2, 4'b0111, "R3 down R5 narrow");
    op(0, 0, 2'b00, 0, 0, '0, 0, 3, 4'hF, "R10 idle hold");
    op(0, 0, 2'b00, 0, 0, '0, 1, 2, 4'hF, "R10 idle hold");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule